// File: doc/BRIEF.md
# Region-Descriptor Memory Protection Checker

This block checks every access that bus masters make against a small table of address regions. Each region has an inclusive start and end address, rounded to 32-byte granules, and a 12-bit rights field. Software programs the table through a word-addressed register port. Each access port presents an address, a size, a kind (read, write or execute), a privilege level and a master number. The block grants the access when at least one valid region fully contains every byte of it and gives the needed right. Rights from overlapping regions add up: a region can only grant, never revoke.

Region 0 is a background region. It always spans the whole address space. The core cannot move its bounds or touch the debugger's rights in it. The core's own rights in region 0 are edited only through a separate alias register. A global enable bit in the control word turns checking off, and every access then passes. A denied access raises its port's bus error in the same cycle and sets a sticky per-port flag. The first faulting address and attributes are held until software clears that flag by writing a one to it.

Top module: `mpu_checker`

## Requirements
- R1: Out of reset, the control word reads 0x1 (checking on, no flags). Region 0 reads start 0x00000000, end 0xFFFFFFFF and rights 0xFFF. Every other region reads valid 0, and any core access that does not cross the top of memory is granted.
- R2: An access of 2^size bytes (size 0..3) at address A matches a region only when A is at or above the start and A+2^size-1 is at or below the inclusive end.
- R3: A region takes part only while bit 0 of its word 3 is set; writing 0 there removes it from the next cycle on.
- R4: When several valid regions contain an access, it is granted if any one of them gives the right. A region without the right does not block a grant from another.
- R5: Writes to region 0's descriptor words (0x40..0x43) have no effect. A write to the alias register (0x10) replaces only rights bits 5:0 of region 0, and the debugger rights, bits 11:6, stay 1.
- R6: While control bit 0 is 0, no port signals an error and no flag is set.
- R7: A denied access asserts acc_err for that port combinationally and sets control bit 16+p at the next edge. The bit stays set until a write to the control word with that bit at 1 clears it.
- R8: The address and attributes {master,user,kind} of the access that set a flag are held at 0x01+2p and 0x02+2p. Later faults do not overwrite them while the flag is set.
- R9: Region start reads back with bits 4:0 forced to 0, and region end with bits 4:0 forced to 1. Region r word k sits at 0x40+4r+k.
- R10: The right used is rights bit master*6+user*3+k, where k is 0 for read (kind 0), 1 for write (kind 1) and 2 for execute (kind 2 or 3).
- R11: An access whose last byte would pass 0xFFFFFFFF is contained in no region, so it is denied whenever checking is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, one cycle later |
| acc_valid | input | NUM_PORTS | Access present per port |
| acc_addr | input | NUM_PORTS x 32 | Access first-byte address |
| acc_size | input | NUM_PORTS x 2 | log2 of access byte count |
| acc_kind | input | NUM_PORTS x 2 | 0 read, 1 write, 2/3 execute |
| acc_user | input | NUM_PORTS | 1 for user mode |
| acc_master | input | NUM_PORTS | 0 core, 1 debugger |
| acc_err | output | NUM_PORTS | Same-cycle bus error per port |

## Verification
The bench probes accesses whose last byte sits exactly on a region end or one byte past it. A design that compared only the first byte would grant a straddling access. It stacks a region that grants over one that does not, to catch an implementation that lets a non-granting match veto the access. It attempts direct writes to region 0, so a design that let the core move the background bounds or clear debugger rights shows up at once. It also drives a second fault while a flag is set, to catch capture registers that overwrite the first fault. Random accesses near programmed bounds on both ports, against a bench model, cover the rights bit index and wrap past the top of memory.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int RIGHTS_PER_MASTER = 6;
  localparam int PERM_W            = 2 * RIGHTS_PER_MASTER;
  localparam int ATTR_W            = 4;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_EXEC2 = 2'd3
  } acc_kind_e;

  // rights bit index: master*6 + user*3 + {read,write,exec}
  function automatic logic [3:0] rights_index(input logic master, input logic user,
                                              input logic [1:0] kind);
    logic [1:0] k;
    k = kind[1] ? 2'd2 : kind;
    return (master ? 4'd6 : 4'd0) + (user ? 4'd3 : 4'd0) + {2'b00, k};
  endfunction
endpackage

// File: rtl/mpu_region.sv
module mpu_region
  import mpu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAN       = 5,
  parameter int NUM_PORTS  = 2,
  parameter bit BACKGROUND = 1'b0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [1:0]                         wr_word,
  input  logic [ADDR_W-1:0]                  wdata,
  input  logic                               alias_wr,
  input  logic [RIGHTS_PER_MASTER-1:0]       alias_rights,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   first_b,
  input  logic [NUM_PORTS-1:0][ADDR_W:0]     last_b,
  input  logic [NUM_PORTS-1:0][3:0]          ridx,
  output logic [NUM_PORTS-1:0]               grant,
  output logic [ADDR_W-1:0]                  rd_start,
  output logic [ADDR_W-1:0]                  rd_end,
  output logic [PERM_W-1:0]                  rd_perm,
  output logic                               rd_valid
);
  localparam int HI_W = ADDR_W - GRAN;

  logic [HI_W-1:0]   start_hi, end_hi;
  logic [PERM_W-1:0] perm;
  logic              valid;

  generate
    if (BACKGROUND) begin : g_bg
      logic [RIGHTS_PER_MASTER-1:0] core_rights_q;
      always_ff @(posedge clk) begin
        if (rst)           core_rights_q <= '1;
        else if (alias_wr) core_rights_q <= alias_rights;
      end
      assign start_hi = '0;
      assign end_hi   = '1;
      assign perm     = {{RIGHTS_PER_MASTER{1'b1}}, core_rights_q};
      assign valid    = 1'b1;
      logic unused_bg;
      assign unused_bg = ^{wr_en, wr_word, wdata};
    end else begin : g_std
      logic [HI_W-1:0]   start_q, end_q;
      logic [PERM_W-1:0] perm_q;
      logic              valid_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          start_q <= '0;
          end_q   <= '0;
          perm_q  <= '0;
          valid_q <= 1'b0;
        end else if (wr_en) begin
          case (wr_word)
            2'd0:    start_q <= wdata[ADDR_W-1:GRAN];
            2'd1:    end_q   <= wdata[ADDR_W-1:GRAN];
            2'd2:    perm_q  <= wdata[PERM_W-1:0];
            default: valid_q <= wdata[0];
          endcase
        end
      end
      assign start_hi = start_q;
      assign end_hi   = end_q;
      assign perm     = perm_q;
      assign valid    = valid_q;
      logic unused_std;
      assign unused_std = ^{alias_wr, alias_rights};

      // R3: clearing the valid bit withdraws every grant in the next cycle
      p_disable_takes_effect_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == 2'd3 && !wdata[0]) |=> (grant == '0));
    end
  endgenerate

  assign rd_start = {start_hi, {GRAN{1'b0}}};
  assign rd_end   = {end_hi, {GRAN{1'b1}}};
  assign rd_perm  = perm;
  assign rd_valid = valid;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      grant[p] = valid
               && (first_b[p] >= rd_start)
               && (last_b[p] <= {1'b0, rd_end})
               && perm[ridx[p]];
    end
  end
endmodule

// File: rtl/mpu_err_capture.sv
module mpu_err_capture #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault,
  input  logic              clr,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [ATTR_W-1:0] fault_attr,
  output logic              flag,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [ATTR_W-1:0] cap_attr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      cap_addr <= '0;
      cap_attr <= '0;
    end else begin
      if (fault && (!flag || clr)) begin
        cap_addr <= fault_addr;
        cap_attr <= fault_attr;
      end
      if (fault)    flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  p_capture_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> ($stable(cap_addr) && $stable(cap_attr)));
  p_capture_first_r8: assert property (@(posedge clk) disable iff (rst)
    (fault && !flag) |=> (cap_addr == $past(fault_addr)));
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 32,
  parameter int GRAN        = 5,
  parameter int REG_AW      = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             reg_wr,
  input  logic [REG_AW-1:0]                reg_addr,
  input  logic [ADDR_W-1:0]                reg_wdata,
  output logic [ADDR_W-1:0]                reg_rdata,
  input  logic [NUM_PORTS-1:0]             acc_valid,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] acc_addr,
  input  logic [NUM_PORTS-1:0][1:0]        acc_size,
  input  logic [NUM_PORTS-1:0][1:0]        acc_kind,
  input  logic [NUM_PORTS-1:0]             acc_user,
  input  logic [NUM_PORTS-1:0]             acc_master,
  output logic [NUM_PORTS-1:0]             acc_err
);
  localparam logic [REG_AW-1:0] A_CTRL   = REG_AW'(8'h00);
  localparam logic [REG_AW-1:0] A_ALIAS  = REG_AW'(8'h10);
  localparam int                WIN_BASE = 'h40;
  localparam int                FLAG_LSB = 16;

  logic                                     enable_q;
  logic [NUM_PORTS-1:0][ADDR_W:0]           last_b;
  logic [NUM_PORTS-1:0][3:0]                ridx;
  logic [NUM_REGIONS-1:0][NUM_PORTS-1:0]    rgrant;
  logic [NUM_PORTS-1:0]                     granted;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]       r_start, r_end;
  logic [NUM_REGIONS-1:0][PERM_W-1:0]       r_perm;
  logic [NUM_REGIONS-1:0]                   r_valid;
  logic [NUM_PORTS-1:0]                     flag, clr;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]         cap_addr;
  logic [NUM_PORTS-1:0][ATTR_W-1:0]         cap_attr;
  logic [ADDR_W-1:0]                        rd_mux;
  logic                                     ctrl_wr, alias_wr;

  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign alias_wr = reg_wr && (reg_addr == A_ALIAS);

  always_ff @(posedge clk) begin
    if (rst)          enable_q <= 1'b1;
    else if (ctrl_wr) enable_q <= reg_wdata[0];
  end

  // per-port byte span and rights bit
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      last_b[p] = {1'b0, acc_addr[p]} + ((ADDR_W+1)'(1) << acc_size[p]) - (ADDR_W+1)'(1);
      ridx[p]   = rights_index(acc_master[p], acc_user[p], acc_kind[p]);
    end
  end

  genvar r;
  generate
    for (r = 0; r < NUM_REGIONS; r++) begin : g_reg
      logic wr_hit;
      assign wr_hit = reg_wr && (reg_addr[REG_AW-1:2] == (REG_AW-2)'((WIN_BASE >> 2) + r));
      mpu_region #(
        .ADDR_W(ADDR_W), .GRAN(GRAN), .NUM_PORTS(NUM_PORTS), .BACKGROUND(r == 0)
      ) i_region (
        .clk(clk), .rst(rst),
        .wr_en(wr_hit), .wr_word(reg_addr[1:0]), .wdata(reg_wdata),
        .alias_wr(alias_wr), .alias_rights(reg_wdata[RIGHTS_PER_MASTER-1:0]),
        .first_b(acc_addr), .last_b(last_b), .ridx(ridx),
        .grant(rgrant[r]),
        .rd_start(r_start[r]), .rd_end(r_end[r]), .rd_perm(r_perm[r]), .rd_valid(r_valid[r])
      );
    end
  endgenerate

  // any matching region that grants wins
  always_comb begin
    granted = '0;
    for (int i = 0; i < NUM_REGIONS; i++) granted |= rgrant[i];
  end

  assign acc_err = acc_valid & {NUM_PORTS{enable_q}} & ~granted;

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      assign clr[p] = ctrl_wr && reg_wdata[FLAG_LSB + p];
      mpu_err_capture #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) i_cap (
        .clk(clk), .rst(rst), .fault(acc_err[p]), .clr(clr[p]),
        .fault_addr(acc_addr[p]),
        .fault_attr({acc_master[p], acc_user[p], acc_kind[p]}),
        .flag(flag[p]), .cap_addr(cap_addr[p]), .cap_attr(cap_attr[p])
      );

      p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        !enable_q |-> !acc_err[p]);
      p_debugger_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid[p] && acc_master[p] && !last_b[p][ADDR_W]) |-> !acc_err[p]);
      p_err_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        acc_err[p] |=> flag[p]);
      p_wrap_denied_r11: assert property (@(posedge clk) disable iff (rst)
        (acc_valid[p] && enable_q && last_b[p][ADDR_W]) |-> acc_err[p]);
    end
  endgenerate

  // read mux, registered
  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_CTRL) begin
      rd_mux[0] = enable_q;
      for (int i = 0; i < NUM_PORTS; i++) rd_mux[FLAG_LSB + i] = flag[i];
    end
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (reg_addr == REG_AW'(1 + 2*i)) rd_mux = cap_addr[i];
      if (reg_addr == REG_AW'(2 + 2*i)) rd_mux = ADDR_W'(cap_attr[i]);
    end
    if (reg_addr == A_ALIAS) rd_mux = ADDR_W'(r_perm[0][RIGHTS_PER_MASTER-1:0]);
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (reg_addr[REG_AW-1:2] == (REG_AW-2)'((WIN_BASE >> 2) + i)) begin
        case (reg_addr[1:0])
          2'd0:    rd_mux = r_start[i];
          2'd1:    rd_mux = r_end[i];
          2'd2:    rd_mux = ADDR_W'(r_perm[i]);
          default: rd_mux = ADDR_W'(r_valid[i]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: tb/test_mpu_checker.sv
module test_mpu_checker;
  localparam int NR = 8;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] acc_valid = '0;
  logic [NP-1:0][31:0] acc_addr = '0;
  logic [NP-1:0][1:0] acc_size = '0;
  logic [NP-1:0][1:0] acc_kind = '0;
  logic [NP-1:0] acc_user = '0;
  logic [NP-1:0] acc_master = '0;
  logic [NP-1:0] acc_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  mpu_checker #(.NUM_REGIONS(NR), .NUM_PORTS(NP)) i_mpu_checker (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_kind(acc_kind), .acc_user(acc_user), .acc_master(acc_master), .acc_err(acc_err)
  );

  // bench model of the programmed state
  logic [31:0] m_start [NR];
  logic [31:0] m_end   [NR];
  logic [11:0] m_perm  [NR];
  logic        m_valid [NR];
  logic        m_en;

  function automatic bit exp_err(input logic [31:0] a, input logic [1:0] sz,
                                 input logic [1:0] k, input logic u, input logic m);
    logic [32:0] last;
    int idx;
    if (!m_en) return 1'b0;
    last = {1'b0, a} + (33'd1 << sz) - 33'd1;
    idx  = (m ? 6 : 0) + (u ? 3 : 0) + (k[1] ? 2 : int'(k));
    for (int r = 0; r < NR; r++)
      if (m_valid[r] && a >= m_start[r] && last <= {1'b0, m_end[r]} && m_perm[r][idx]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int r;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 8'h00) m_en = d[0];
    if (a == 8'h10) m_perm[0][5:0] = d[5:0];
    if (a >= 8'h44 && a < 8'(8'h40 + 4*NR)) begin
      r = int'(a[7:2]) - 16;
      case (a[1:0])
        2'd0: m_start[r] = {d[31:5], 5'h00};
        2'd1: m_end[r]   = {d[31:5], 5'h1F};
        2'd2: m_perm[r]  = d[11:0];
        default: m_valid[r] = d[0];
      endcase
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic access(input int p, input logic [31:0] a, input logic [1:0] sz,
                        input logic [1:0] k, input logic u, input logic m, output logic e);
    @(negedge clk);
    acc_valid[p] = 1'b1; acc_addr[p] = a; acc_size[p] = sz;
    acc_kind[p] = k; acc_user[p] = u; acc_master[p] = m;
    #5 e = acc_err[p];
    @(posedge clk);
    #1 acc_valid[p] = 1'b0;
  endtask

  task automatic chk_acc(input string req, input int p, input logic [31:0] a,
                         input logic [1:0] sz, input logic [1:0] k, input logic u,
                         input logic m, input logic exp);
    logic e;
    access(p, a, sz, k, u, m, e);
    chk(req, {31'd0, e}, {31'd0, exp});
  endtask

  initial begin
    #3_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    for (int r = 0; r < NR; r++) begin
      m_start[r] = 0; m_end[r] = 32'h1F; m_perm[r] = 0; m_valid[r] = 0;
    end
    m_start[0] = 0; m_end[0] = 32'hFFFF_FFFF; m_perm[0] = 12'hFFF; m_valid[0] = 1; m_en = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 32'h1);
    rd(8'h41, d); chk("R1 r0 end", d, 32'hFFFF_FFFF);
    rd(8'h42, d); chk("R1 r0 rights", d, 32'hFFF);
    rd(8'h4F, d); chk("R1 r3 valid", d, 32'h0);
    chk_acc("R1 core granted", 0, 32'h8000_1234, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0);

    // R5 region 0 protected, alias edits core rights only
    wr(8'h40, 32'h0000_1000);
    wr(8'h42, 32'h0);
    wr(8'h43, 32'h0);
    rd(8'h40, d); chk("R5 r0 start kept", d, 32'h0);
    rd(8'h42, d); chk("R5 r0 rights kept", d, 32'hFFF);
    wr(8'h10, 32'h0);
    rd(8'h42, d); chk("R5 alias core bits", d, 32'hFC0);
    chk_acc("R5 core denied", 0, 32'h0000_4000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    chk_acc("R5 debugger kept", 1, 32'h0000_4000, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0);
    wr(8'h00, 32'h0003_0001);  // clear flags

    // R9 granularity
    wr(8'h44, 32'h1234_5677); rd(8'h44, d); chk("R9 start low zero", d, 32'h1234_5660);
    wr(8'h45, 32'h2000_0000); rd(8'h45, d); chk("R9 end low ones", d, 32'h2000_001F);

    // R2 containment, R10 rights index: region1 0x1000..0x10FF supervisor core read
    wr(8'h44, 32'h1000); wr(8'h45, 32'h10E0); wr(8'h46, 32'h001); wr(8'h47, 32'h1);
    chk_acc("R2 last byte on end", 0, 32'h10FC, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    chk_acc("R2 straddle end", 0, 32'h10FD, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
    chk_acc("R2 below start", 0, 32'h0FFF, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    chk_acc("R2 8-byte at start", 0, 32'h1000, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
    chk_acc("R10 write lacks right", 0, 32'h1000, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1);
    chk_acc("R10 user read lacks right", 0, 32'h1000, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1);
    wr(8'h46, 32'h020);  // user exec bit 5
    chk_acc("R10 kind3 is exec", 0, 32'h1010, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0);
    wr(8'h46, 32'h001);

    // R4 overlap OR: region2 0x1080..0x11FF supervisor core write
    wr(8'h48, 32'h1080); wr(8'h49, 32'h11E0); wr(8'h4A, 32'h002); wr(8'h4B, 32'h1);
    chk_acc("R4 write via region2", 0, 32'h10A0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0);
    chk_acc("R4 read via region1", 0, 32'h1080, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    chk_acc("R4 read outside region1", 0, 32'h1100, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);

    // R3 valid bit
    wr(8'h47, 32'h0);
    chk_acc("R3 disabled region", 0, 32'h1000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);

    // R7 / R8 flags and capture
    wr(8'h00, 32'h0003_0001);
    rd(8'h00, d); chk("R7 flags cleared", d, 32'h1);
    chk_acc("R7 fault", 0, 32'h0000_2004, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1);
    rd(8'h00, d); chk("R7 flag set", d, 32'h0001_0001);
    chk_acc("R8 second fault", 0, 32'h0000_3008, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1);
    rd(8'h01, d); chk("R8 addr held", d, 32'h0000_2004);
    rd(8'h02, d); chk("R8 attr held", d, 32'h5);
    wr(8'h00, 32'h0001_0001);
    rd(8'h00, d); chk("R7 w1c", d, 32'h1);

    // R6 bypass
    wr(8'h00, 32'h0);
    chk_acc("R6 bypass", 0, 32'h0000_5000, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0);
    rd(8'h00, d); chk("R6 no flag", d, 32'h0);
    wr(8'h00, 32'h1);

    // R11 wrap past top
    wr(8'h10, 32'h3F);
    chk_acc("R11 core wrap", 0, 32'hFFFF_FFFE, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
    chk_acc("R11 debugger wrap", 1, 32'hFFFF_FFFC, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1);
    chk_acc("R11 last word ok", 0, 32'hFFFF_FFFC, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    wr(8'h10, 32'h0);

    // random mix, regions 1..NR-1 and both ports (R2 R3 R4 R10)
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 400; it++) begin
      int r, p;
      logic [31:0] s, a;
      logic [1:0] sz, k;
      logic u, m;
      if (it % 40 == 0) begin
        for (int q = 1; q < NR; q++) begin
          s = $urandom & 32'h0000_FFE0;
          wr(8'(64 + 4*q), s);
          wr(8'(65 + 4*q), s + ($urandom & 32'h3FF));
          wr(8'(66 + 4*q), $urandom);
          wr(8'(67 + 4*q), $urandom & 1);
        end
      end
      r  = 1 + int'($urandom % (NR - 1));
      a  = ($urandom & 1) ? m_start[r] : m_end[r];
      a  = a + 32'($urandom % 17) - 32'd8;
      sz = 2'($urandom); k = 2'($urandom);
      u  = 1'($urandom); m = 1'($urandom % 4 == 0);
      p  = int'($urandom % NP);
      access(p, a, sz, k, u, m, e);
      chk("R4 random", {31'd0, e}, {31'd0, exp_err(a, sz, k, u, m)});
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule